// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block builds the status byte that a flash device returns on bus reads while its program/erase controller is working, while a failed operation is waiting to be cleared, and while an erase is suspended and the read address falls inside a block that is being erased. The controller tells it which operation has started and what it is doing now: running, suspended, or failed. The read path tells it whether the current read address is in an erasing block or in a block that failed. A strobe marks each completed read.

Three outputs go back to the read path and the pins. The first is the status byte. The second is a select line that chooses between that byte and array data. The third is a busy level for the ready/busy pin. Two toggle bits advance on completed reads. One advances on every status read while the operation runs. The other advances only on reads that land in erasing blocks, or in failed blocks after an erase error. Software compares the two bits to find out which blocks are suspended or bad. Array storage and command decoding are outside this block.

Top module: `pe_status_unit`

## Requirements
- R1: `op_kind` encodings 2'b01 (program) and 2'b00 (reserved) are both treated as a program. For a program, bit 7 of `status` is the inverse of `prog_bit` as captured at the `op_start` pulse.
- R2: `op_kind` encodings 2'b10 (whole-array erase) and 2'b11 (block-list erase) are erases. For an erase, bit 7 is 0 while `suspended` is low and 1 while `suspended` is high.
- R3: Bit 6 inverts once for each cycle where `rd_strobe` is high and `sel_status` is high. It does not invert while an erase is suspended.
- R4: Bit 5 equals `err_flag`. While `err_flag` is high, `sel_status` stays high even after `op_active` has dropped.
- R5: For an erase, bit 3 equals `timer_bit`. For a program, bit 3 is 0.
- R6: With `err_flag` low during an erase, bit 2 inverts on each selected strobed read with `in_erase_blk` high, whether or not the erase is suspended. It keeps its value on any other read, and on every read during a program.
- R7: With `err_flag` high during an erase, bit 2 inverts only on strobed reads with `blk_err` high. A read with `blk_err` low leaves bit 2 unchanged.
- R8: `sel_status` is high under any of three conditions: the operation is active and not suspended; it is active, suspended, and `in_erase_blk` is high; or `err_flag` is high. In every other case `sel_status` is low.
- R9: `rb_busy` is high exactly while `op_active` is high and no erase is suspended. `suspended` has no effect on a program, on this output or on any other output.
- R10: An `op_start` pulse clears bits 6 and 2 and takes priority over a strobe in the same cycle. Bits 4, 1 and 0 are always 0. After reset, `status` is 8'h00 and `sel_status` and `rb_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when an operation begins |
| op_kind | input | 2 | Operation type, captured at `op_start` |
| prog_bit | input | 1 | Bit-7 value being programmed, captured at `op_start` |
| op_active | input | 1 | Controller is working on the operation |
| suspended | input | 1 | Erase is suspended |
| in_erase_blk | input | 1 | Read address lies in a block being erased |
| err_flag | input | 1 | Operation failed; held until cleared by the controller |
| blk_err | input | 1 | Read address lies in a block that failed to erase |
| timer_bit | input | 1 | Erase timer has expired (erasing has begun) |
| rd_strobe | input | 1 | A bus read completes this cycle |
| status | output | 8 | Status byte |
| sel_status | output | 1 | 1: return `status`; 0: return array data |
| rb_busy | output | 1 | 1: drive the ready/busy pin low |

## Verification
The assertions watch several rules on every cycle. Each toggle bit must invert one cycle after an advancing read and hold its value otherwise. Bit 6 must stay frozen across a suspend. An operation start must clear both toggles. The failure bit and the select line must follow the failure flag. Busy must imply that status is selected, and a running erase must poll as 0. What the assertions cannot show is the full matrix of operation kind, captured bit, suspend, block and failure flags together with the toggle history that builds up across many reads. The bench covers that by sweeping every flag combination under every operation kind, with its own model of both toggles.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  localparam int STATUS_W = 8;
  localparam int POS_POLL = 7;
  localparam int POS_TGL  = 6;
  localparam int POS_FAIL = 5;
  localparam int POS_TMR  = 3;
  localparam int POS_ALT  = 2;
  localparam int N_TGL    = 2;
  localparam int IDX_TGL  = 0;
  localparam int IDX_ALT  = 1;

  typedef enum logic [1:0] {
    OP_RSVD  = 2'b00,
    OP_PROG  = 2'b01,
    OP_CHIP  = 2'b10,
    OP_BLOCK = 2'b11
  } op_kind_e;

  function automatic logic f_is_erase(input op_kind_e kind);
    return (kind == OP_CHIP) || (kind == OP_BLOCK);
  endfunction

  function automatic logic f_poll_bit(input logic is_erase, input logic pb,
                                      input logic susp_eff);
    return is_erase ? susp_eff : ~pb;
  endfunction

  function automatic logic f_select(input logic active, input logic susp_eff,
                                    input logic in_blk, input logic err);
    return (active & ~susp_eff) | (active & susp_eff & in_blk) | err;
  endfunction

  function automatic logic f_alt_hit(input logic is_erase, input logic err,
                                     input logic blk_err, input logic in_blk);
    return is_erase & (err ? blk_err : in_blk);
  endfunction

endpackage

// File: rtl/pe_op_capture.sv
module pe_op_capture
  import pe_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     op_start,
  input  logic [1:0] op_kind,
  input  logic     prog_bit,
  output op_kind_e kind_q,
  output logic     pb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_RSVD;
      pb_q   <= 1'b1;
    end else if (op_start) begin
      kind_q <= op_kind_e'(op_kind);
      pb_q   <= prog_bit;
    end
  end
endmodule

// File: rtl/pe_toggle_flop.sv
module pe_toggle_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/pe_status_compose.sv
module pe_status_compose
  import pe_status_pkg::*;
(
  input  logic                is_erase,
  input  logic                pb,
  input  logic                susp_eff,
  input  logic                err,
  input  logic                timer,
  input  logic [N_TGL-1:0]    tgl,
  output logic [STATUS_W-1:0] status
);
  always_comb begin
    status           = '0;
    status[POS_POLL] = f_poll_bit(is_erase, pb, susp_eff);
    status[POS_TGL]  = tgl[IDX_TGL];
    status[POS_FAIL] = err;
    status[POS_TMR]  = is_erase & timer;
    status[POS_ALT]  = tgl[IDX_ALT];
  end
endmodule

// File: rtl/pe_status_unit.sv
module pe_status_unit
  import pe_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_start,
  input  logic [1:0]          op_kind,
  input  logic                prog_bit,
  input  logic                op_active,
  input  logic                suspended,
  input  logic                in_erase_blk,
  input  logic                err_flag,
  input  logic                blk_err,
  input  logic                timer_bit,
  input  logic                rd_strobe,
  output logic [STATUS_W-1:0] status,
  output logic                sel_status,
  output logic                rb_busy
);
  op_kind_e         kind_q;
  logic             pb_q;
  logic             is_erase;
  logic             susp_eff;
  logic             rd_fire;
  logic             t6_adv;
  logic             t2_adv;
  logic [N_TGL-1:0] tgl_adv;
  logic [N_TGL-1:0] tgl_q;

  pe_op_capture u_cap (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_bit(prog_bit), .kind_q(kind_q), .pb_q(pb_q)
  );

  assign is_erase   = f_is_erase(kind_q);
  assign susp_eff   = suspended & is_erase;
  assign sel_status = f_select(op_active, susp_eff, in_erase_blk, err_flag);
  assign rb_busy    = op_active & ~susp_eff;

  // named read events, visible to the checker
  assign rd_fire = rd_strobe & sel_status;
  assign t6_adv  = rd_fire & ~susp_eff;
  assign t2_adv  = rd_fire & f_alt_hit(is_erase, err_flag, blk_err, in_erase_blk);

  assign tgl_adv[IDX_TGL] = t6_adv;
  assign tgl_adv[IDX_ALT] = t2_adv;

  for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
    pe_toggle_flop u_tf (
      .clk(clk), .rst_n(rst_n), .clr(op_start), .adv(tgl_adv[g]), .q(tgl_q[g])
    );
  end

  pe_status_compose u_comp (
    .is_erase(is_erase), .pb(pb_q), .susp_eff(susp_eff), .err(err_flag),
    .timer(timer_bit), .tgl(tgl_q), .status(status)
  );
endmodule

// File: rtl/pe_status_unit_chk.sv
module pe_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       prog_bit,
  input logic       op_active,
  input logic       err_flag,
  input logic [7:0] status,
  input logic       sel_status,
  input logic       rb_busy,
  input logic       is_erase,
  input logic       susp_eff,
  input logic       t6_adv,
  input logic       t2_adv
);
  p_dq7_prog_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !op_kind[1]) |=> (status[7] == !$past(prog_bit)));

  p_dq7_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_erase && op_active && !susp_eff) |-> (status[7] == 1'b0));

  p_dq6_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t6_adv && !op_start) |=> (status[6] != $past(status[6])));

  p_dq6_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_eff && !op_start) |=> $stable(status[6]));

  p_fail_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (status[5] && sel_status));

  p_dq2_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_adv && !op_start) |=> (status[2] != $past(status[2])));

  p_dq2_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!t2_adv && !op_start) |=> $stable(status[2]));

  p_busy_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy |-> sel_status);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (status[6] == 1'b0 && status[2] == 1'b0));

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (status[4] == 1'b0 && status[1] == 1'b0 && status[0] == 1'b0));
endmodule

bind pe_status_unit pe_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
  .prog_bit(prog_bit), .op_active(op_active), .err_flag(err_flag),
  .status(status), .sel_status(sel_status), .rb_busy(rb_busy),
  .is_erase(is_erase), .susp_eff(susp_eff), .t6_adv(t6_adv), .t2_adv(t2_adv)
);

// File: tb/pe_status_unit_tb.sv
module pe_status_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, prog_bit = 0, op_active = 0, suspended = 0;
  logic in_erase_blk = 0, err_flag = 0, blk_err = 0, timer_bit = 0, rd_strobe = 0;
  logic [1:0] op_kind = 2'b00;
  logic [7:0] status;
  logic sel_status, rb_busy;
  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m6, m2, m_erase, m_pb;

  always #4 clk = ~clk;

  pe_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_bit(prog_bit), .op_active(op_active), .suspended(suspended),
    .in_erase_blk(in_erase_blk), .err_flag(err_flag), .blk_err(blk_err),
    .timer_bit(timer_bit), .rd_strobe(rd_strobe), .status(status),
    .sel_status(sel_status), .rb_busy(rb_busy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] k, input logic pb);
    @(negedge clk);
    op_kind = k; prog_bit = pb; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    m6 = 0; m2 = 0; m_erase = k[1]; m_pb = pb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset status", status, 8'h00);
    chk("R10 reset sel", {7'd0, sel_status}, 8'd0);
    chk("R10 reset busy", {7'd0, rb_busy}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      for (int pb = 0; pb < 2; pb++) begin
        start_op(k[1:0], pb[0]);
        #1;
        chk("R10 start clears", {5'd0, status[6], 1'b0, status[2]}, 8'd0);
        for (int v = 0; v < 64; v++) begin
          bit act, su, ib, er, be, tm, se, es, alt;
          {act, su, ib, er, be, tm} = v[5:0];
          se  = su & m_erase;
          es  = (act & !se) | (act & se & ib) | er;
          alt = m_erase & (er ? be : ib);
          @(negedge clk);
          op_active = act; suspended = su; in_erase_blk = ib;
          err_flag = er; blk_err = be; timer_bit = tm; rd_strobe = 1'b1;
          #1;
          chk("R8 select", {7'd0, sel_status}, {7'd0, es});
          chk("R9 busy", {7'd0, rb_busy}, {7'd0, act & !se});
          if (es) begin
            chk(m_erase ? "R2 poll bit" : "R1 poll bit", {7'd0, status[7]},
                {7'd0, m_erase ? se : !m_pb});
            chk("R3 toggle bit", {7'd0, status[6]}, {7'd0, m6});
            chk("R4 fail bit", {7'd0, status[5]}, {7'd0, er});
            chk("R5 timer bit", {7'd0, status[3]}, {7'd0, m_erase & tm});
            chk(er ? "R7 alt toggle" : "R6 alt toggle", {7'd0, status[2]}, {7'd0, m2});
            chk("R10 zero bits", {5'd0, status[4], status[1], status[0]}, 8'd0);
          end
          if (es && !se) m6 = !m6;
          if (es && alt) m2 = !m2;
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        #1;
        chk("R3 toggle after sweep", {7'd0, status[6]}, {7'd0, m6});
        chk("R6 alt after sweep", {7'd0, status[2]}, {7'd0, m2});
      end
    end

    // op_start wins over a strobe in the same cycle
    start_op(2'b11, 1'b0);
    @(negedge clk);
    op_active = 1; suspended = 0; in_erase_blk = 1; err_flag = 0; rd_strobe = 1;
    @(negedge clk);
    #1;
    chk("R3 advanced once", {7'd0, status[6]}, 8'd1);
    chk("R6 advanced once", {7'd0, status[2]}, 8'd1);
    @(negedge clk);
    op_start = 1'b1; op_kind = 2'b10;
    @(negedge clk);
    op_start = 1'b0; rd_strobe = 1'b0;
    #1;
    chk("R10 start beats strobe", {5'd0, status[6], 1'b0, status[2]}, 8'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule